// File: doc/BRIEF.md
# BLAKE2s Block Compression Engine

This engine applies the BLAKE2s compression function to one 64-byte message block. The caller presents the eight-word chaining value, the 64-bit byte counter, the two finalization flag words, a counter increment and sixteen little-endian message words. It then pulses `start_i`. The engine captures everything on that edge and advances the counter. It builds the sixteen-word working vector and runs ten rounds of column and diagonal mixing. Finally it folds the working vector back into the chaining value. The new chaining value and counter then appear on the outputs, and `done_o` is raised for one cycle.

The engine time-shares `G_LANES` mixing units (1, 2 or 4). Each unit applies one full mixing function per cycle. A round takes `8/G_LANES` cycles, and the fold takes one extra cycle. To hash a message of several blocks, the caller feeds `h_o`/`t_o` back as the inputs of the next block. It uses an increment of 64 for every block except a short last block, and sets `f0_i` to all ones on the last block.

Top module: `b2s_compress`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_o` and `done_o` are 0 and `h_o` and `t_o` are zero until the first block completes.
- R2: `start_i` is accepted on a rising edge where `busy_o` is 0. `busy_o` is 1 for exactly `LAT = 80/G_LANES + 1` cycles after that edge. `done_o` is 1 for exactly one cycle, namely the first cycle in which `busy_o` is back at 0.
- R3: In the done cycle, `t_o` equals `t_i + inc_i` modulo 2^64, with `inc_i` zero-extended, so the carry out of bits 31:0 propagates into bits 63:32.
- R4: The working vector holds the chaining words in positions 0 to 7. Positions 8 to 15 hold the IV words 6A09E667, BB67AE85, 3C6EF372, A54FF53A, 510E527F, 9B05688C, 1F83D9AB and 5BE0CD19. Positions 12 and 13 are XORed with the low and high halves of the advanced counter, and positions 14 and 15 with `f0_i` and `f1_i`.
- R5: Each round mixes the columns (0,4,8,12) to (3,7,11,15) first, then the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). Mix k of round r uses the message words at entries 2k and 2k+1 of the standard ten-row BLAKE2s permutation. Message word j sits in `msg_i[32j+31:32j]`, so byte 0 of the block is bits 7:0. Chaining word i sits in `h_i[32i+31:32i]`. All sums are modulo 2^32.
- R6: Each mix of (a,b,c,d) with words x and y performs these steps in order: a+=b+x, d=ror(d^a,16), c+=d, b=ror(b^c,12), a+=b+y, d=ror(d^a,8), c+=d, b=ror(b^c,7). After ten rounds, output word i is h[i]^v[i]^v[i+8].
- R7: `start_i` and all data inputs are ignored while `busy_o` is 1. The result equals that of the data captured at the accepting edge.
- R8: `h_o` and `t_o` change only on the edge that raises `done_o`, and hold their values otherwise.
- R9: A `start_i` that is high in the done cycle is accepted, so blocks run back to back with no idle cycle.
- R10: Given the chaining value IV with word 0 XORed with 01010020, the counter at 0, an increment of 3, `f0_i` of FFFFFFFF and message word 0 of 00636261, the engine produces the 256-bit "abc" digest 508c5e8c…86675982 as little-endian words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin compressing the presented block |
| h_i | input | 256 | Chaining value in, word i at bits 32i+31:32i |
| t_i | input | 64 | Byte counter before this block |
| inc_i | input | 32 | Counter increment for this block |
| f0_i | input | 32 | First finalization flag word |
| f1_i | input | 32 | Second finalization flag word |
| msg_i | input | 512 | Sixteen message words, word j at bits 32j+31:32j |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle pulse when the new outputs are valid |
| h_o | output | 256 | Updated chaining value |
| t_o | output | 64 | Advanced byte counter |

## Verification
Completion of one block and acceptance of the next can share one cycle. The done cycle is also the first idle cycle, so a `start_i` held high across it launches the next block on the very edge that follows. The bench holds `start_i` high through a whole block and swaps the data while the engine is busy. A behavioural model, advanced every clock, then checks three things: the first result belongs to the original data, the engine stays busy in the cycle after done, and the second result belongs to the data present in the done cycle.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
  localparam int ROUNDS = 10;
  localparam int VWORDS = 16;
  localparam int HWORDS = 8;

  typedef logic [31:0] word_t;
  typedef word_t [VWORDS-1:0] vec_t;
  typedef word_t [HWORDS-1:0] hstate_t;

  function automatic word_t rotr(word_t w, int unsigned n);
    return (w >> n) | (w << (32 - n));
  endfunction

  function automatic word_t iv_word(logic [2:0] i);
    case (i)
      3'd0: return 32'h6A09E667;
      3'd1: return 32'hBB67AE85;
      3'd2: return 32'h3C6EF372;
      3'd3: return 32'hA54FF53A;
      3'd4: return 32'h510E527F;
      3'd5: return 32'h9B05688C;
      3'd6: return 32'h1F83D9AB;
      default: return 32'h5BE0CD19;
    endcase
  endfunction

  // entry k of the round's permutation at bits 4k+3:4k
  function automatic logic [63:0] sigma_row(logic [3:0] r);
    case (r)
      4'd0: return 64'hFEDCBA9876543210;
      4'd1: return 64'h357B20C16DF984AE;
      4'd2: return 64'h491763EADF250C8B;
      4'd3: return 64'h8F04A562EBCD1397;
      4'd4: return 64'hD386CB1EFA427509;
      4'd5: return 64'h91EF57D438B0A6C2;
      4'd6: return 64'hB8293670A4DEF15C;
      4'd7: return 64'hA2684F05931CE7BD;
      4'd8: return 64'h5A417D2C803B9EF6;
      4'd9: return 64'h0DC3E9BF5167482A;
      default: return 64'h0;
    endcase
  endfunction

  // mix g (0..3 columns, 4..7 diagonals) -> {d,c,b,a} word indices
  function automatic logic [15:0] g_map(logic [2:0] g);
    logic [1:0] j, jb, jc, jd;
    j  = g[1:0];
    jb = g[2] ? j + 2'd1 : j;
    jc = g[2] ? j + 2'd2 : j;
    jd = g[2] ? j + 2'd3 : j;
    return {2'b11, jd, 2'b10, jc, 2'b01, jb, 2'b00, j};
  endfunction
endpackage

// File: rtl/b2s_mix.sv
module b2s_mix
  import b2s_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  input  word_t x_i,
  input  word_t y_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;

  always_comb begin
    a1  = a_i + b_i + x_i;
    d1  = rotr(d_i ^ a1, 16);
    c1  = c_i + d1;
    b1  = rotr(b_i ^ c1, 12);
    a_o = a1 + b1 + y_i;
    d_o = rotr(d1 ^ a_o, 8);
    c_o = c1 + d_o;
    b_o = rotr(b1 ^ c_o, 7);
  end
endmodule

// File: rtl/b2s_msg_pick.sv
module b2s_msg_pick
  import b2s_pkg::*;
(
  input  vec_t       msg_i,
  input  logic [3:0] rnd_i,
  input  logic [2:0] g_i,
  output word_t      x_o,
  output word_t      y_o
);
  logic [63:0] row;
  logic [7:0]  pair;

  always_comb begin
    row  = sigma_row(rnd_i);
    pair = row[8*g_i +: 8];
    x_o  = msg_i[pair[3:0]];
    y_o  = msg_i[pair[7:4]];
  end
endmodule

// File: rtl/b2s_vinit.sv
module b2s_vinit
  import b2s_pkg::*;
(
  input  hstate_t     h_i,
  input  logic [63:0] t_i,
  input  word_t       f0_i,
  input  word_t       f1_i,
  output vec_t        v_o
);
  always_comb begin
    for (int i = 0; i < HWORDS; i++) begin
      v_o[i]          = h_i[i];
      v_o[i + HWORDS] = iv_word(3'(i));
    end
    v_o[12] = v_o[12] ^ t_i[31:0];
    v_o[13] = v_o[13] ^ t_i[63:32];
    v_o[14] = v_o[14] ^ f0_i;
    v_o[15] = v_o[15] ^ f1_i;
  end
endmodule

// File: rtl/b2s_compress.sv
module b2s_compress
  import b2s_pkg::*;
#(
  parameter int G_LANES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [255:0] h_i,
  input  logic [63:0]  t_i,
  input  logic [31:0]  inc_i,
  input  logic [31:0]  f0_i,
  input  logic [31:0]  f1_i,
  input  logic [511:0] msg_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [255:0] h_o,
  output logic [63:0]  t_o
);
  localparam int SUBS  = 8 / G_LANES;
  localparam int SUB_W = (SUBS > 1) ? $clog2(SUBS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD} st_e;

  st_e              st_q;
  logic [3:0]       rnd_q;
  logic [SUB_W-1:0] sub_q;
  vec_t             v_q, v_nxt, v_init;
  vec_t             msg_q;
  hstate_t          h_q, h_fold;
  logic [63:0]      t_q, t_adv;

  word_t       ln_a [G_LANES];
  word_t       ln_b [G_LANES];
  word_t       ln_c [G_LANES];
  word_t       ln_d [G_LANES];
  logic [15:0] ln_map [G_LANES];

  assign busy_o = (st_q != ST_IDLE);
  assign t_adv  = t_i + {32'b0, inc_i};

  b2s_vinit u_vinit (
    .h_i (h_i),
    .t_i (t_adv),
    .f0_i(f0_i),
    .f1_i(f1_i),
    .v_o (v_init)
  );

  for (genvar l = 0; l < G_LANES; l++) begin : g_lane
    logic [2:0]  g_num;
    logic [15:0] map;
    word_t       x, y;

    assign g_num     = 3'(int'(sub_q) * G_LANES + l);
    assign map       = g_map(g_num);
    assign ln_map[l] = map;

    b2s_msg_pick u_pick (
      .msg_i(msg_q),
      .rnd_i(rnd_q),
      .g_i  (g_num),
      .x_o  (x),
      .y_o  (y)
    );

    b2s_mix u_mix (
      .a_i(v_q[map[3:0]]),
      .b_i(v_q[map[7:4]]),
      .c_i(v_q[map[11:8]]),
      .d_i(v_q[map[15:12]]),
      .x_i(x),
      .y_i(y),
      .a_o(ln_a[l]),
      .b_o(ln_b[l]),
      .c_o(ln_c[l]),
      .d_o(ln_d[l])
    );
  end

  always_comb begin
    v_nxt = v_q;
    for (int l = 0; l < G_LANES; l++) begin
      v_nxt[ln_map[l][3:0]]   = ln_a[l];
      v_nxt[ln_map[l][7:4]]   = ln_b[l];
      v_nxt[ln_map[l][11:8]]  = ln_c[l];
      v_nxt[ln_map[l][15:12]] = ln_d[l];
    end
  end

  always_comb begin
    for (int i = 0; i < HWORDS; i++) h_fold[i] = h_q[i] ^ v_q[i] ^ v_q[i + HWORDS];
  end

  // control and outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rnd_q  <= '0;
      sub_q  <= '0;
      done_o <= 1'b0;
      h_o    <= '0;
      t_o    <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RUN;
          rnd_q <= '0;
          sub_q <= '0;
        end
        ST_RUN: begin
          if (sub_q == SUB_W'(SUBS - 1)) begin
            sub_q <= '0;
            if (rnd_q == 4'(ROUNDS - 1)) st_q <= ST_FOLD;
            else                         rnd_q <= rnd_q + 4'd1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        default: begin
          h_o    <= h_fold;
          t_o    <= t_q;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  // datapath, no reset needed
  always_ff @(posedge clk_i) begin
    if (st_q == ST_IDLE && start_i) begin
      msg_q <= msg_i;
      h_q   <= h_i;
      t_q   <= t_adv;
      v_q   <= v_init;
    end else if (st_q == ST_RUN) begin
      v_q <= v_nxt;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(h_o) && $stable(t_o))); // R8
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && start_i) |=> $stable(msg_q)); // R7
  AST_RND_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rnd_q < 4'(ROUNDS))); // R5
  AST_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> busy_o); // R9
endmodule

// File: tb/b2s_compress_bench.sv
module b2s_compress_bench;
  localparam int G_LANES = 2;
  localparam int LAT     = 80 / G_LANES + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] h_in = '0;
  logic [63:0]  t_in = '0;
  logic [31:0]  inc = '0, f0 = '0, f1 = '0;
  logic [511:0] msg = '0;
  logic         busy, done;
  logic [255:0] h_out;
  logic [63:0]  t_out;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  b2s_compress #(.G_LANES(G_LANES)) u_b2s_compress (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .h_i(h_in), .t_i(t_in),
    .inc_i(inc), .f0_i(f0), .f1_i(f1), .msg_i(msg),
    .busy_o(busy), .done_o(done), .h_o(h_out), .t_o(t_out)
  );

  function automatic logic [31:0] ivw(int i);
    logic [31:0] tab [8] = '{32'h6A09E667, 32'hBB67AE85, 32'h3C6EF372, 32'hA54FF53A,
                             32'h510E527F, 32'h9B05688C, 32'h1F83D9AB, 32'h5BE0CD19};
    return tab[i];
  endfunction

  function automatic int sg(int r, int k);
    logic [63:0] row [10] = '{64'hFEDCBA9876543210, 64'h357B20C16DF984AE,
      64'h491763EADF250C8B, 64'h8F04A562EBCD1397, 64'hD386CB1EFA427509,
      64'h91EF57D438B0A6C2, 64'hB8293670A4DEF15C, 64'hA2684F05931CE7BD,
      64'h5A417D2C803B9EF6, 64'h0DC3E9BF5167482A};
    return int'(row[r][4*k +: 4]);
  endfunction

  function automatic logic [31:0] ror(logic [31:0] w, int n);
    return (w >> n) | (w << (32 - n));
  endfunction

  function automatic logic [255:0] ref_cmp(logic [255:0] h, logic [63:0] t,
      logic [31:0] g0, logic [31:0] g1, logic [511:0] m);
    logic [31:0] v [16];
    logic [255:0] r;
    for (int i = 0; i < 8; i++) begin
      v[i] = h[32*i +: 32];
      v[i+8] = ivw(i);
    end
    v[12] ^= t[31:0]; v[13] ^= t[63:32]; v[14] ^= g0; v[15] ^= g1;
    for (int rd = 0; rd < 10; rd++) begin
      for (int g = 0; g < 8; g++) begin
        int j = g % 4, s = (g < 4) ? 0 : 1;
        int a = j, b = 4 + (j + s) % 4, c = 8 + (j + 2*s) % 4, d = 12 + (j + 3*s) % 4;
        logic [31:0] x = m[32*sg(rd, 2*g) +: 32];
        logic [31:0] y = m[32*sg(rd, 2*g+1) +: 32];
        v[a] = v[a] + v[b] + x; v[d] = ror(v[d] ^ v[a], 16);
        v[c] = v[c] + v[d];     v[b] = ror(v[b] ^ v[c], 12);
        v[a] = v[a] + v[b] + y; v[d] = ror(v[d] ^ v[a], 8);
        v[c] = v[c] + v[d];     v[b] = ror(v[b] ^ v[c], 7);
      end
    end
    for (int i = 0; i < 8; i++) r[32*i +: 32] = h[32*i +: 32] ^ v[i] ^ v[i+8];
    return r;
  endfunction

  // cycle model
  logic         m_busy, m_done;
  logic [255:0] m_h, p_h;
  logic [63:0]  m_t, p_t;
  int           m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_h <= '0; m_t <= '0; m_cnt <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1;
          m_cnt  <= LAT - 1;
          p_t    <= t_in + {32'b0, inc};
          p_h    <= ref_cmp(h_in, t_in + {32'b0, inc}, f0, f1, msg);
        end
      end else if (m_cnt == 0) begin
        m_busy <= 0; m_done <= 1; m_h <= p_h; m_t <= p_t;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy_o", 256'(busy), 256'(m_busy));
      chk("R2 done_o", 256'(done), 256'(m_done));
      chk("R4 R5 R6 R8 h_o", h_out, m_h);
      chk("R3 R8 t_o", 256'(t_out), 256'(m_t));
    end
  end

  function automatic logic [511:0] rnd_blk();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic drive(logic [255:0] h, logic [63:0] t, logic [31:0] i_n,
                       logic [31:0] g0, logic [31:0] g1, logic [511:0] m);
    h_in = h; t_in = t; inc = i_n; f0 = g0; f1 = g1; msg = m;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!m_done);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [255:0] h_abc, ha, hb, ea;
    logic [511:0] ma, mb;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy_o", 256'(busy), 256'(0));
    chk("R1 done_o", 256'(done), 256'(0));
    chk("R1 h_o", h_out, '0);
    chk("R1 t_o", 256'(t_out), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 h_o after release", h_out, '0);

    // R10: known digest
    for (int i = 0; i < 8; i++) h_abc[32*i +: 32] = ivw(i);
    h_abc[31:0] ^= 32'h01010020;
    @(negedge clk);
    drive(h_abc, 64'd0, 32'd3, 32'hFFFFFFFF, 32'd0, 512'h00636261);
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    chk("R10 abc digest", h_out,
        256'h82596786_4C9B994D_293AD69E_208B4537_2F45EB4E_A32BA7E1_E2147C32_8C5E8C50);
    chk("R3 abc counter", 256'(t_out), 256'd3);

    // R3: carry from low word, and full 64-bit wrap
    @(negedge clk);
    drive({8{32'h0F1E2D3C}}, 64'h00000005_FFFFFFF0, 32'd64, 32'd0, 32'd0, rnd_blk());
    start = 1; @(negedge clk); start = 0;
    wait_done();
    chk("R3 carry", 256'(t_out), 256'(64'h00000006_00000030));
    @(negedge clk);
    drive({8{32'h13579BDF}}, 64'hFFFFFFFF_FFFFFFC8, 32'd64, 32'hFFFFFFFF, 32'hFFFFFFFF, rnd_blk());
    start = 1; @(negedge clk); start = 0;
    wait_done();
    chk("R3 wrap", 256'(t_out), 256'(64'h8));

    // R7: start and data changed while busy
    ha = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    ma = rnd_blk();
    ea = ref_cmp(ha, 64'd128 + 64'd64, 32'd0, 32'd0, ma);
    @(negedge clk);
    drive(ha, 64'd128, 32'd64, 32'd0, 32'd0, ma);
    start = 1; @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    drive(~ha, 64'd7, 32'd1, 32'h55, 32'hAA, rnd_blk());
    start = 1;
    repeat (3) @(negedge clk);
    start = 0;
    wait_done();
    chk("R7 busy start ignored", h_out, ea);
    @(negedge clk);
    chk("R7 no restart", 256'(busy), 256'(0));

    // R9: start held through done, data swapped while busy
    ha = {8{32'hA5A5_0F0F}}; ma = rnd_blk();
    hb = {8{32'h3C3C_F0F0}}; mb = rnd_blk();
    @(negedge clk);
    drive(ha, 64'd0, 32'd64, 32'd0, 32'd0, ma);
    start = 1;
    @(negedge clk);
    drive(hb, 64'd64, 32'd17, 32'hFFFFFFFF, 32'd0, mb);
    wait_done();
    chk("R9 first result", h_out, ref_cmp(ha, 64'd64, 32'd0, 32'd0, ma));
    @(negedge clk);
    start = 0;
    chk("R9 busy after done", 256'(busy), 256'(1));
    wait_done();
    chk("R9 second result", h_out, ref_cmp(hb, 64'd81, 32'hFFFFFFFF, 32'd0, mb));
    chk("R9 second counter", 256'(t_out), 256'd81);

    // R4 R5 R6: a few random blocks against the model
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      drive({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom}, $urandom, $urandom, $urandom, rnd_blk());
      start = 1; @(negedge clk); start = 0;
      wait_done();
      chk("R4 R5 R6 random block", h_out, m_h);
    end

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule